// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block sits passively beside one load/store port, between a compute unit that issues loads and stores and the memory side that answers them. Every cycle it compares the port's control signals with the handshake rules and keeps a record of the first rule that was broken. It drives nothing on the port. It does not model memory and does not look at data values, so the data buses are not among its inputs.

Inside, a state machine follows each transaction. The states are: `MS_IDLE` (no transaction open), `MS_LD_WAIT` (load requested, address not yet accepted), `MS_LD_ACKED` (load address accepted, waiting for read data), `MS_ST_WAIT` (store requested, address not yet accepted), `MS_ST_ACKED` (store address accepted, waiting for write data) and `MS_ST_DRAIN` (the cycle after write data, in which busy must be low).

The transitions are:
- request: from any state to `MS_LD_WAIT` or `MS_ST_WAIT` when a request strobe is high. If both strobes are high, the load strobe wins.
- accept: from `MS_LD_WAIT` to `MS_LD_ACKED`, and from `MS_ST_WAIT` to `MS_ST_ACKED`.
- fault end: from either wait state to `MS_IDLE` on an address exception.
- read end: from `MS_LD_ACKED` to `MS_IDLE` on read-data valid.
- write: from `MS_ST_ACKED` to `MS_ST_DRAIN` on write-data valid.
- drain end: from `MS_ST_DRAIN` to `MS_IDLE`.
- abort: to `MS_IDLE` from any state.

A separate unit holds a copy of the address and length once the requester has flagged them valid. A priority latch records the error code.

Top module: `ldst_port_monitor`

## Requirements
- R1: If busy is high in the same cycle as exactly one request strobe, the violation is code 1.
- R2: If both request strobes are high in one cycle while busy is low, the violation is code 2.
- R3: Busy must be high in every cycle of an open transaction, from the cycle after the request up to, but not including, the cycle in which the transaction ends. Busy high while no transaction is open is also a violation. Both cases are code 5.
- R4: Once address-valid is seen in an open transaction, address-valid must stay high, and the address and length must stay unchanged, in every later cycle where busy is high. Otherwise the violation is code 3.
- R5: Address accept and address exception may each fire at most once per transaction and never both, and they may fire only before the address is accepted. A repeated or stray pulse is code 4, and so is a pulse that lasts more than one cycle.
- R6: An address exception ends the transaction, and busy must be low in that same cycle, otherwise code 5.
- R7: Read-data valid is legal only in `MS_LD_ACKED`, where busy must be low in that same cycle (code 5 otherwise). Read-data valid at any other time is code 4.
- R8: Write-data valid before the store address is accepted, or with no store open, is code 6. In `MS_ST_ACKED`, busy must be high in the write cycle and low in the following cycle (code 5 otherwise). Write-data valid in that following cycle is code 4.
- R9: `err_flag` goes high and `err_code` takes the 3-bit code one cycle after the violating cycle. Only the first violation is kept until reset. When several codes fire in one cycle, the lowest code is recorded.
- R10: A high `abort` returns tracking to `MS_IDLE`, drops any held address, and suppresses every check in that cycle.
- R11: Reset leaves `err_flag` at 0 and `err_code` at 0.
- R12: A new request with busy low is legal in the cycle a load completes, in the cycle an exception fires, and in the drain cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_ld | input | 1 | Load request strobe |
| req_st | input | 1 | Store request strobe |
| xfer_len | input | LEN_W (4) | Access length, held together with the address |
| addr | input | ADDR_W (48) | Access address |
| addr_vld | input | 1 | Address valid flag from the requester |
| busy | input | 1 | Port busy from the responder |
| addr_ack | input | 1 | Address accepted pulse |
| addr_fault | input | 1 | Address exception pulse |
| rd_vld | input | 1 | Read data valid pulse |
| wr_vld | input | 1 | Write data valid pulse |
| abort | input | 1 | Abandon tracking and skip checks this cycle |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violation, 0 when none |

## Verification
Two outcomes can fall in the same cycle: the end of one transaction and the request that opens the next. This happens when read-data valid or an exception arrives with busy low, or in a store's drain cycle. The bench provokes each case by raising a request strobe in exactly that cycle, then runs the new transaction to a legal finish and expects no error. A second same-cycle case is two violations together, for example an overlap with both strobes high. This case is judged by requiring the lower code.

// File: rtl/ldst_mon_pkg.sv
package ldst_mon_pkg;

    localparam int unsigned NUM_CODES = 6;
    localparam int unsigned CODE_W    = $clog2(NUM_CODES + 1);

    typedef enum logic [2:0] {
        MS_IDLE     = 3'd0,
        MS_LD_WAIT  = 3'd1,
        MS_LD_ACKED = 3'd2,
        MS_ST_WAIT  = 3'd3,
        MS_ST_ACKED = 3'd4,
        MS_ST_DRAIN = 3'd5
    } mon_state_e;

    // Bit i of a violation vector stands for code i+1.
    localparam int unsigned V_OVERLAP  = 0;
    localparam int unsigned V_DUAL     = 1;
    localparam int unsigned V_ADDR_MOV = 2;
    localparam int unsigned V_PULSE    = 3;
    localparam int unsigned V_BUSY     = 4;
    localparam int unsigned V_EARLY_WR = 5;

endpackage

// File: rtl/ldst_mon_fsm.sv
module ldst_mon_fsm
    import ldst_mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_ld,
    input  logic                 req_st,
    input  logic                 busy,
    input  logic                 addr_ack,
    input  logic                 addr_fault,
    input  logic                 rd_vld,
    input  logic                 wr_vld,
    input  logic                 abort,
    output mon_state_e           state_q,
    output logic                 in_txn,
    output logic                 start,
    output logic [NUM_CODES-1:0] viol
);

    mon_state_e state_d;
    logic       ends;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    assign start  = req_ld | req_st;
    assign in_txn = (state_q == MS_LD_WAIT) || (state_q == MS_LD_ACKED) ||
                    (state_q == MS_ST_WAIT) || (state_q == MS_ST_ACKED);

    // Next state and violation decode
    always_comb begin
        state_d = state_q;
        viol    = '0;
        ends    = 1'b0;

        viol[V_OVERLAP] = start & busy;
        viol[V_DUAL]    = req_ld & req_st;

        unique case (state_q)
            MS_IDLE: begin
                if (busy) viol[V_BUSY] = 1'b1;
                if (addr_ack | addr_fault | rd_vld) viol[V_PULSE] = 1'b1;
                if (wr_vld) viol[V_EARLY_WR] = 1'b1;
            end
            MS_LD_WAIT: begin
                if (addr_ack & addr_fault) viol[V_PULSE] = 1'b1;
                if (rd_vld) viol[V_PULSE] = 1'b1;
                if (wr_vld) viol[V_EARLY_WR] = 1'b1;
                if (addr_fault) begin
                    if (busy) viol[V_BUSY] = 1'b1;
                    ends = 1'b1;
                end else begin
                    if (!busy) viol[V_BUSY] = 1'b1;
                    if (addr_ack) state_d = MS_LD_ACKED;
                end
            end
            MS_LD_ACKED: begin
                if (addr_ack | addr_fault) viol[V_PULSE] = 1'b1;
                if (wr_vld) viol[V_EARLY_WR] = 1'b1;
                if (rd_vld) begin
                    if (busy) viol[V_BUSY] = 1'b1;
                    ends = 1'b1;
                end else if (!busy) begin
                    viol[V_BUSY] = 1'b1;
                end
            end
            MS_ST_WAIT: begin
                if (addr_ack & addr_fault) viol[V_PULSE] = 1'b1;
                if (rd_vld) viol[V_PULSE] = 1'b1;
                if (wr_vld) viol[V_EARLY_WR] = 1'b1;
                if (addr_fault) begin
                    if (busy) viol[V_BUSY] = 1'b1;
                    ends = 1'b1;
                end else begin
                    if (!busy) viol[V_BUSY] = 1'b1;
                    if (addr_ack) state_d = MS_ST_ACKED;
                end
            end
            MS_ST_ACKED: begin
                if (addr_ack | addr_fault | rd_vld) viol[V_PULSE] = 1'b1;
                if (!busy) viol[V_BUSY] = 1'b1;
                if (wr_vld) state_d = MS_ST_DRAIN;
            end
            MS_ST_DRAIN: begin
                if (busy) viol[V_BUSY] = 1'b1;
                if (addr_ack | addr_fault | rd_vld | wr_vld) viol[V_PULSE] = 1'b1;
                ends = 1'b1;
            end
            default: begin
                ends = 1'b1;
            end
        endcase

        if (ends) state_d = MS_IDLE;
        if (req_ld)      state_d = MS_LD_WAIT;
        else if (req_st) state_d = MS_ST_WAIT;

        if (abort) begin
            state_d = MS_IDLE;
            viol    = '0;
        end
    end

endmodule

// File: rtl/ldst_mon_addr_hold.sv
module ldst_mon_addr_hold #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_txn,
    input  logic              start,
    input  logic              busy,
    input  logic              abort,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              moved
);

    localparam int unsigned SNAP_W = ADDR_W + LEN_W;

    logic              held_q;
    logic [SNAP_W-1:0] snap_q;
    logic [SNAP_W-1:0] live;

    assign live = {xfer_len, addr};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            snap_q <= '0;
        end else if (abort || start || !in_txn) begin
            held_q <= 1'b0;
        end else if (addr_vld && !held_q) begin
            held_q <= 1'b1;
            snap_q <= live;
        end
    end

    assign moved = !abort && in_txn && held_q && busy &&
                   (!addr_vld || (live != snap_q));

endmodule

// File: rtl/ldst_mon_err_latch.sv
module ldst_mon_err_latch
    import ldst_mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CODES-1:0] viol,
    output logic                 err_flag,
    output logic [CODE_W-1:0]    err_code
);

    logic [CODE_W-1:0] pick;

    // Lowest code wins
    always_comb begin
        pick = '0;
        for (int i = NUM_CODES - 1; i >= 0; i--) begin
            if (viol[i]) pick = CODE_W'(i + 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_code <= '0;
        end else if (!err_flag && (viol != '0)) begin
            err_flag <= 1'b1;
            err_code <= pick;
        end
    end

endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
    import ldst_mon_pkg::*;
#(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_ld,
    input  logic              req_st,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_vld,
    input  logic              busy,
    input  logic              addr_ack,
    input  logic              addr_fault,
    input  logic              rd_vld,
    input  logic              wr_vld,
    input  logic              abort,
    output logic              err_flag,
    output logic [2:0]        err_code
);

    mon_state_e           state_q;
    logic                 in_txn;
    logic                 start;
    logic                 moved;
    logic [NUM_CODES-1:0] fsm_viol;
    logic [NUM_CODES-1:0] all_viol;

    ldst_mon_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_ld     (req_ld),
        .req_st     (req_st),
        .busy       (busy),
        .addr_ack   (addr_ack),
        .addr_fault (addr_fault),
        .rd_vld     (rd_vld),
        .wr_vld     (wr_vld),
        .abort      (abort),
        .state_q    (state_q),
        .in_txn     (in_txn),
        .start      (start),
        .viol       (fsm_viol)
    );

    ldst_mon_addr_hold #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_txn   (in_txn),
        .start    (start),
        .busy     (busy),
        .abort    (abort),
        .addr_vld (addr_vld),
        .addr     (addr),
        .xfer_len (xfer_len),
        .moved    (moved)
    );

    always_comb begin
        all_viol             = fsm_viol;
        all_viol[V_ADDR_MOV] = moved;
    end

    ldst_mon_err_latch u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .viol     (all_viol),
        .err_flag (err_flag),
        .err_code (err_code)
    );

endmodule

// File: rtl/ldst_port_monitor_chk.sv
module ldst_port_monitor_chk
    import ldst_mon_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_ld,
    input logic       req_st,
    input logic       busy,
    input logic       wr_vld,
    input logic       abort,
    input logic       err_flag,
    input logic [2:0] err_code,
    input mon_state_e state_q
);

    p_overlap_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort && !err_flag && busy && (req_ld ^ req_st)) |=> (err_flag && err_code == 3'd1));

    p_dual_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort && !err_flag && !busy && req_ld && req_st) |=> (err_flag && err_code == 3'd2));

    p_store_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort && state_q == MS_ST_ACKED && wr_vld && !req_ld && !req_st) |=> (state_q == MS_ST_DRAIN));

    p_first_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> (err_flag && $stable(err_code)));

    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !err_flag) |=> !err_flag);

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == MS_IDLE));

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!err_flag && err_code == 3'd0));

endmodule

bind ldst_port_monitor ldst_port_monitor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ld   (req_ld),
    .req_st   (req_st),
    .busy     (busy),
    .wr_vld   (wr_vld),
    .abort    (abort),
    .err_flag (err_flag),
    .err_code (err_code),
    .state_q  (state_q)
);

// File: tb/test_ldst_port_monitor.sv
module test_ldst_port_monitor;

    localparam logic [47:0] A0 = 48'h0000_1234_5678;
    localparam logic [47:0] A1 = 48'h0ABC_0000_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_ld = 0, req_st = 0, addr_vld = 0, busy = 0;
    logic        addr_ack = 0, addr_fault = 0, rd_vld = 0, wr_vld = 0, abort = 0;
    logic [3:0]  xfer_len = 4'd8;
    logic [47:0] addr = A0;
    logic        err_flag;
    logic [2:0]  err_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ldst_port_monitor i_ldst_port_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_ld     (req_ld),
        .req_st     (req_st),
        .xfer_len   (xfer_len),
        .addr       (addr),
        .addr_vld   (addr_vld),
        .busy       (busy),
        .addr_ack   (addr_ack),
        .addr_fault (addr_fault),
        .rd_vld     (rd_vld),
        .wr_vld     (wr_vld),
        .abort      (abort),
        .err_flag   (err_flag),
        .err_code   (err_code)
    );

    // One port cycle: drive at the falling edge, sample just after the rising edge.
    task automatic cyc(input logic ld = 0, input logic st = 0, input logic av = 0,
                       input logic bz = 0, input logic ak = 0, input logic fl = 0,
                       input logic rv = 0, input logic wv = 0, input logic ab = 0,
                       input logic [47:0] a = A0, input logic [3:0] ln = 4'd8);
        @(negedge clk);
        req_ld = ld; req_st = st; addr_vld = av; busy = bz;
        addr_ack = ak; addr_fault = fl; rd_vld = rv; wr_vld = wv; abort = ab;
        addr = a; xfer_len = ln;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_ld = 0; req_st = 0; addr_vld = 0; busy = 0;
        addr_ack = 0; addr_fault = 0; rd_vld = 0; wr_vld = 0; abort = 0;
        addr = A0; xfer_len = 4'd8;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk(input string tag, input logic [2:0] exp_code);
        logic exp_flag;
        exp_flag = (exp_code != 3'd0);
        checks++;
        if (err_flag !== exp_flag || err_code !== exp_code) begin
            errors++;
            $display("FAIL %s: flag=%0d code=%0d expected flag=%0d code=%0d",
                     tag, err_flag, err_code, exp_flag, exp_code);
        end
    endtask

    task automatic run_all();
        do_reset();
        chk("R11 reset state", 3'd0);

        // Legal load, store and exception
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ak(1));
        cyc(.bz(1), .av(1)); cyc(.av(1), .rv(1)); cyc();
        chk("R7 legal load", 3'd0);
        cyc(.st(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ak(1));
        cyc(.bz(1), .av(1), .wv(1)); cyc(); cyc();
        chk("R8 legal store", 3'd0);
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.av(1), .fl(1)); cyc();
        chk("R6 legal exception", 3'd0);

        // R12: completion and new request in one cycle
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ak(1));
        cyc(.av(1), .rv(1), .st(1));
        cyc(.bz(1), .av(1), .a(A1)); cyc(.bz(1), .av(1), .a(A1), .ak(1));
        cyc(.bz(1), .av(1), .a(A1), .wv(1));
        cyc(.ld(1));
        cyc(.bz(1), .av(1)); cyc(.av(1), .fl(1), .st(1));
        cyc(.bz(1), .av(1), .a(A1)); cyc(.bz(1), .av(1), .a(A1), .ak(1));
        cyc(.bz(1), .av(1), .a(A1), .wv(1)); cyc(); cyc();
        chk("R12 back-to-back requests", 3'd0);

        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .st(1));
        chk("R1 overlap", 3'd1);

        do_reset();
        cyc(.ld(1), .st(1));
        chk("R2 both strobes", 3'd2);

        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ld(1), .st(1));
        chk("R9 lowest code wins", 3'd1);

        do_reset();
        cyc(.ld(1)); cyc(.av(1));
        chk("R3 busy not raised", 3'd5);

        do_reset();
        cyc(.bz(1));
        chk("R3 busy while idle", 3'd5);

        // R4: every address bit
        for (int b = 0; b < 48; b++) begin
            do_reset();
            cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .a(A0 ^ (48'd1 << b)));
            chk($sformatf("R4 address bit %0d changed", b), 3'd3);
        end
        do_reset();
        cyc(.st(1)); cyc(.bz(1), .av(1)); cyc(.bz(1));
        chk("R4 valid dropped", 3'd3);
        do_reset();
        cyc(.st(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ln(4'd4));
        chk("R4 length changed", 3'd3);
        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ak(1));
        cyc(.av(1), .rv(1), .a(A1));
        chk("R4 address free once busy low", 3'd0);

        // R5: accept pulse length sweep
        for (int len = 1; len <= 3; len++) begin
            do_reset();
            cyc(.ld(1)); cyc(.bz(1), .av(1));
            for (int k = 0; k < len; k++) cyc(.bz(1), .av(1), .ak(1));
            cyc(.av(1), .rv(1)); cyc();
            chk($sformatf("R5 accept pulse of %0d cycles", len), (len == 1) ? 3'd0 : 3'd4);
        end
        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.av(1), .ak(1), .fl(1));
        chk("R5 accept and exception together", 3'd4);
        do_reset();
        cyc(.ak(1));
        chk("R5 stray accept", 3'd4);
        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.av(1), .fl(1)); cyc(.fl(1));
        chk("R5 exception two cycles", 3'd4);

        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .fl(1));
        chk("R6 exception with busy high", 3'd5);

        // R7: busy fall offset sweep around read data
        for (int d = -1; d <= 1; d++) begin
            do_reset();
            cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ak(1));
            cyc(.bz(d >= 0), .av(1));
            cyc(.bz(d == 1), .av(1), .rv(1)); cyc();
            chk($sformatf("R7 busy offset %0d", d), (d == 0) ? 3'd0 : 3'd5);
        end
        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.av(1), .rv(1));
        chk("R7 read data before accept", 3'd4);
        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ak(1));
        cyc(.av(1), .rv(1)); cyc(.rv(1));
        chk("R7 read data two cycles", 3'd4);

        // R8: busy fall offset sweep around write data
        for (int d = 0; d <= 2; d++) begin
            do_reset();
            cyc(.st(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ak(1));
            cyc(.bz(d >= 1), .av(1), .wv(1));
            cyc(.bz(d >= 2)); cyc();
            chk($sformatf("R8 busy low %0d cycles after write", d), (d == 1) ? 3'd0 : 3'd5);
        end
        do_reset();
        cyc(.st(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .wv(1));
        chk("R8 write before accept", 3'd6);
        do_reset();
        cyc(.wv(1));
        chk("R8 write with no store", 3'd6);
        do_reset();
        cyc(.st(1)); cyc(.bz(1), .av(1)); cyc(.bz(1), .av(1), .ak(1));
        cyc(.bz(1), .av(1), .wv(1)); cyc(.wv(1));
        chk("R8 write two cycles", 3'd4);

        do_reset();
        cyc(.bz(1)); cyc(.ld(1), .st(1)); cyc();
        chk("R9 first error kept", 3'd5);

        // R10: abort
        do_reset();
        cyc(.ld(1)); cyc(.bz(1), .av(1)); cyc(.ab(1));
        cyc(.ld(1)); cyc(.bz(1), .av(1), .a(A1)); cyc(.bz(1), .av(1), .a(A1), .ak(1));
        cyc(.av(1), .a(A1), .rv(1)); cyc();
        chk("R10 abort then fresh load", 3'd0);
        cyc(.ld(1), .st(1), .bz(1), .ab(1)); cyc();
        chk("R10 checks skipped in abort cycle", 3'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not end, expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule